// File: doc/BRIEF.md
# Reloadable 8-bit Event Timer with Toggle and PWM Output

This block is an up-counting timer for a small microcontroller peripheral. Its count is advanced by a qualified clock. That clock is one of several prescaled tick inputs or an edge on an external event pin. The counted edge of the event pin can be set to rising, falling or both. When a qualified clock arrives while the count is at its maximum, an overflow occurs. The counter then restarts from a software-held reload value or from zero, and a sticky interrupt flag is raised.

An output pin can stay low, invert on each overflow, or carry a PWM waveform. In PWM mode the counter always runs a full 256-step frame from zero. The pin is high while the count is below a compare value taken from the reload register. A register write changes the duty either at the next frame or at once, depending on the reload setting.

Software reaches the block through a synchronous write port with four register selects. The prescaler chain is outside this block, so the tick inputs arrive already divided. A standby bit in the mode register halts counting and leaves the stored settings untouched.

Top module: `evt_timer8`

## Requirements
- R1: A write to select 0 (outside PWM mode) stores the byte as reload value and loads it into the counter. Each single-cycle pulse on tick input i, with the mode source field set to i (0..2), adds one to the count in the next cycle. Pulses on other tick inputs leave the count unchanged. Mode byte (select 1) layout: bit0 reload enable, bits[2:1] source, bits[4:3] edge, bits[6:5] output mode, bit7 standby.
- R2: Overflow happens only on a qualified clock that finds the count already at 0xFF. Reaching 0xFF raises no flag.
- R3: On overflow outside PWM mode, the counter loads the reload value when reload is enabled and loads 0x00 when it is not. Counting then goes on from there.
- R4: Every overflow sets the interrupt flag. The flag stays set until a select-3 write with bit0=1; a select-3 write with bit0=0 leaves it alone. An overflow in the same cycle as a clear leaves the flag set.
- R5: With source code 3, the event pin is counted after a two-stage synchronizer. Edge code 0 counts rising edges, code 1 counts falling edges, and codes 2 and 3 count both. The count changes on the third rising clock edge after the pin changes. Tick inputs have no effect in this mode.
- R6: In both-edge mode, pin changes two clock cycles apart are each counted once.
- R7: With output code 1, the pin inverts on each overflow and holds between overflows.
- R8: With output code 2, the counter always restarts at 0x00 on overflow. The pin is high while the count is below the compare value and low otherwise. Output codes 0 and 3 hold the pin low.
- R9: In PWM mode with reload disabled, a select-0 write leaves the count alone and the compare value takes the new byte at the next overflow. With reload enabled, the write sets the count to 0x00 and the compare value to the byte in the next cycle.
- R10: While mode bit7 is set, qualified clocks do not change the count or the output. Clearing the bit resumes counting with the earlier settings.
- R11: After reset the count, flag, pin, reload value, compare value and mode byte are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 reload, 1 mode, 2 unused, 3 flag clear |
| regWrData | input | 8 | Register write data |
| tickIn | input | 3 | Prescaled tick pulses, one per source code |
| evtIn | input | 1 | Asynchronous external event pin |
| countOut | output | 8 | Current count |
| irqFlag | output | 1 | Sticky overflow flag |
| timerOut | output | 1 | Toggle or PWM output pin |

## Verification
A register write or a tick pulse is applied for one cycle from a falling edge. The count, flag and pin show its effect after the next rising edge, so the bench samples on the following falling edge. An event-pin change needs three rising edges, two for the synchronizer and one for the counter, so the bench waits three falling edges before it samples. The PWM pin follows the count combinationally and is checked in the same sample as the count. Every sample compares all three outputs against an arithmetic model that is stepped only when the bench knows a clock qualified.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTHB = 2'd3
  } edgeSel_e;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_PWM    = 2'd2,
    OUT_OFFB   = 2'd3
  } outMode_e;

  localparam logic [1:0] SEL_RELOAD = 2'd0;
  localparam logic [1:0] SEL_MODE   = 2'd1;
  localparam logic [1:0] SEL_CLEAR  = 2'd3;

  typedef struct packed {
    logic     reloadEn;
    outMode_e outMode;
    logic     standby;
  } dpCfg_t;

  typedef struct packed {
    logic inc;
    logic wrReload;
    logic clrFlag;
  } dpStrobe_t;

endpackage

// File: rtl/timer8_ctrl.sv
module timer8_ctrl
  import timer8_pkg::*;
#(
  parameter int W           = 8,
  parameter int NUM_TICKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [W-1:0]         regWrData,
  input  logic [NUM_TICKS-1:0] tickIn,
  input  logic                 evtIn,
  output dpCfg_t               cfg,
  output dpStrobe_t            stb
);

  localparam int SRC_W     = $clog2(NUM_TICKS + 1);
  localparam int RELOAD_B  = 0;
  localparam int SRC_LSB   = 1;
  localparam int EDGE_LSB  = SRC_LSB + SRC_W;
  localparam int OUT_LSB   = EDGE_LSB + 2;
  localparam int STBY_B    = OUT_LSB + 2;
  localparam logic [SRC_W-1:0] EXT_CODE = SRC_W'(NUM_TICKS);

  logic [W-1:0]           modeReg;
  logic [SRC_W-1:0]       srcSel;
  edgeSel_e               edgeSel;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   evtPrev;
  logic                   evtNow;
  logic                   evtPulse;
  logic                   tickSel;
  logic                   riseOnly;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (regWrEn && regSel == SEL_MODE) modeReg <= regWrData;
  end

  assign srcSel       = modeReg[EDGE_LSB-1:SRC_LSB];
  assign edgeSel      = edgeSel_e'(modeReg[OUT_LSB-1:EDGE_LSB]);
  assign cfg.reloadEn = modeReg[RELOAD_B];
  assign cfg.outMode  = outMode_e'(modeReg[STBY_B-1:OUT_LSB]);
  assign cfg.standby  = |modeReg[W-1:STBY_B];

  // event pin synchronizer and edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      evtPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], evtIn};
      evtPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign evtNow = syncQ[SYNC_STAGES-1];

  always_comb begin
    unique case (edgeSel)
      EDGE_RISE: evtPulse = evtNow & ~evtPrev;
      EDGE_FALL: evtPulse = ~evtNow & evtPrev;
      default:   evtPulse = evtNow ^ evtPrev;
    endcase
  end

  always_comb begin
    tickSel = 1'b0;
    if (srcSel == EXT_CODE) tickSel = evtPulse;
    else begin
      for (int i = 0; i < NUM_TICKS; i++)
        if (srcSel == SRC_W'(i)) tickSel = tickIn[i];
    end
  end

  assign stb.inc      = tickSel & ~cfg.standby;
  assign stb.wrReload = regWrEn && (regSel == SEL_RELOAD);
  assign stb.clrFlag  = regWrEn && (regSel == SEL_CLEAR) && regWrData[0];

  assign riseOnly = (srcSel == EXT_CODE) && (edgeSel == EDGE_RISE);

  // a rising edge needs two transitions, so rising-only pulses never touch
  assert_rise_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && riseOnly) |=> !(stb.inc && riseOnly));

endmodule

// File: rtl/timer8_dp.sv
module timer8_dp
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCfg_t       cfg,
  input  dpStrobe_t    stb,
  input  logic [W-1:0] regWrData,
  output logic [W-1:0] count,
  output logic         irqFlag,
  output logic         timerOut
);

  localparam logic [W-1:0] MAX_CNT = {W{1'b1}};

  logic [W-1:0] reloadReg;
  logic [W-1:0] cmpReg;
  logic         togReg;
  logic         pwmMode;
  logic         loadNow;
  logic         ovf;

  assign pwmMode = (cfg.outMode == OUT_PWM);
  assign loadNow = stb.wrReload && !(pwmMode && !cfg.reloadEn);
  assign ovf     = stb.inc && !loadNow && (count == MAX_CNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (loadNow) begin
      count <= pwmMode ? '0 : regWrData;
    end else if (stb.inc) begin
      if (count == MAX_CNT) count <= (pwmMode || !cfg.reloadEn) ? '0 : reloadReg;
      else                  count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) reloadReg <= '0;
    else if (stb.wrReload) reloadReg <= regWrData;
  end

  // compare value: at once under reload, otherwise at frame start
  always_ff @(posedge clk) begin
    if (!rstN) cmpReg <= '0;
    else if (stb.wrReload && pwmMode && cfg.reloadEn) cmpReg <= regWrData;
    else if (ovf) cmpReg <= reloadReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      togReg  <= 1'b0;
    end else begin
      if (ovf) irqFlag <= 1'b1;
      else if (stb.clrFlag) irqFlag <= 1'b0;
      if (ovf) togReg <= ~togReg;
    end
  end

  always_comb begin
    unique case (cfg.outMode)
      OUT_TOGGLE: timerOut = togReg;
      OUT_PWM:    timerOut = (count < cmpReg);
      default:    timerOut = 1'b0;
    endcase
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && !stb.wrReload && count != MAX_CNT) |=> count == $past(count) + 1'b1);

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && !stb.wrReload && count == MAX_CNT && !pwmMode && cfg.reloadEn)
      |=> count == $past(reloadReg));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && !stb.wrReload && count == MAX_CNT) |=> irqFlag);

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !stb.clrFlag) |=> irqFlag);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && cfg.outMode == OUT_TOGGLE && $stable(cfg.outMode))
      |=> timerOut != $past(timerOut));

  assert_standby_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.standby && !stb.wrReload) |=> $stable(count));

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import timer8_pkg::*;
#(
  parameter int W           = 8,
  parameter int NUM_TICKS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [W-1:0]         regWrData,
  input  logic [NUM_TICKS-1:0] tickIn,
  input  logic                 evtIn,
  output logic [W-1:0]         countOut,
  output logic                 irqFlag,
  output logic                 timerOut
);

  dpCfg_t    cfg;
  dpStrobe_t stb;

  timer8_ctrl #(.W(W), .NUM_TICKS(NUM_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .tickIn(tickIn), .evtIn(evtIn),
    .cfg(cfg), .stb(stb)
  );

  timer8_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .regWrData(regWrData),
    .count(countOut), .irqFlag(irqFlag), .timerOut(timerOut)
  );

endmodule

// File: tb/test_evt_timer8.sv
module test_evt_timer8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic [2:0] tickIn = '0;
  logic       evtIn = 1'b0;
  logic [7:0] countOut;
  logic       irqFlag;
  logic       timerOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // bench model
  logic [7:0] mCnt = 0, mRel = 0, mCmp = 0;
  bit mFlag = 0, mTog = 0, mRelEn = 0, mStby = 0;
  int mSrc = 0, mEdge = 0, mOut = 0;
  bit mEvt = 0;

  evt_timer8 i_evt_timer8 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .tickIn(tickIn), .evtIn(evtIn),
    .countOut(countOut), .irqFlag(irqFlag), .timerOut(timerOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit expOut();
    if (mOut == 1) return mTog;
    if (mOut == 2) return (mCnt < mCmp);
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkAll(input string req);
    chk(req, countOut, mCnt, "count");
    chk(req, irqFlag, mFlag, "flag");
    chk(req, timerOut, expOut(), "out");
  endtask

  task automatic mStep();
    if (mCnt == 8'hFF) begin
      mFlag = 1; mTog = ~mTog; mCmp = mRel;
      mCnt = (mOut == 2 || !mRelEn) ? 8'h00 : mRel;
    end else mCnt = mCnt + 1;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    if (sel == 0) begin
      mRel = d;
      if (mOut == 2) begin
        if (mRelEn) begin mCnt = 0; mCmp = d; end
      end else mCnt = d;
    end else if (sel == 1) begin
      mRelEn = d[0]; mSrc = d[2:1]; mEdge = d[4:3]; mOut = d[6:5]; mStby = d[7];
    end else if (sel == 3 && d[0]) mFlag = 0;
  endtask

  task automatic setMode(input bit rel, input int src, input int edg, input int om, input bit sb);
    wrReg(2'd1, {sb, 2'(om), 2'(edg), 2'(src), rel});
  endtask

  task automatic pulseTick(input int idx);
    @(negedge clk);
    tickIn[idx] = 1'b1;
    @(negedge clk);
    tickIn = '0;
    if (mSrc == idx && !mStby) mStep();
  endtask

  function automatic bit edgeHit(input bit oldV, input bit newV);
    if (oldV == newV) return 0;
    if (mEdge == 0) return newV;
    if (mEdge == 1) return !newV;
    return 1;
  endfunction

  task automatic setEvt(input bit v);
    @(negedge clk);
    evtIn = v;
    repeat (3) @(negedge clk);
    if (mSrc == 3 && !mStby && edgeHit(mEvt, v)) mStep();
    mEvt = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkAll("R11");

    // R1 / R2 / R3: counting per tick source, unselected ticks ignored
    for (int src = 0; src < 3; src++) begin
      setMode(0, src, 0, 0, 0);
      for (int s = 0; s < 3; s++) begin
        wrReg(2'd0, (s == 0) ? 8'h00 : (s == 1) ? 8'h7E : 8'hFC);
        chkAll("R1");
        for (int k = 0; k < 6; k++) begin
          pulseTick(src); chkAll("R1_R2_R3");
          pulseTick((src + 1) % 3); chkAll("R1");
        end
      end
      wrReg(2'd3, 8'h01); chkAll("R4");
    end

    // R2: reaching 0xFF raises no flag
    wrReg(2'd0, 8'hFE);
    pulseTick(2); chkAll("R2"); chk("R2", irqFlag, 0, "flag at FF");
    pulseTick(2); chkAll("R2");

    // R3 reload mode
    setMode(1, 0, 0, 0, 0);
    wrReg(2'd0, 8'hFA);
    for (int k = 0; k < 14; k++) begin pulseTick(0); chkAll("R3"); end

    // R4 clear with bit0=0 ignored, with bit0=1 clears; set beats clear
    wrReg(2'd3, 8'h00); chkAll("R4");
    wrReg(2'd3, 8'h01); chkAll("R4");
    wrReg(2'd0, 8'hFF);
    @(negedge clk);
    regWrEn = 1; regSel = 2'd3; regWrData = 8'h01; tickIn[0] = 1'b1;
    @(negedge clk);
    regWrEn = 0; tickIn = '0;
    mStep();
    chkAll("R4"); chk("R4", irqFlag, 1, "set over clear");
    wrReg(2'd3, 8'h01);

    // R5 event counting for each edge code
    for (int e = 0; e < 4; e++) begin
      setMode(0, 3, e, 0, 0);
      wrReg(2'd0, 8'h10);
      for (int k = 0; k < 6; k++) begin
        setEvt(~mEvt); chkAll("R5");
        pulseTick(k % 3); chkAll("R5");
      end
    end

    // R6 both edges two cycles apart
    setMode(0, 3, 2, 0, 0);
    wrReg(2'd0, 8'h20);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); evtIn = ~evtIn;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    mCnt = mCnt + 6; mEvt = evtIn;
    chkAll("R6");

    // R7 toggle output with reload
    setMode(1, 0, 0, 1, 0);
    wrReg(2'd0, 8'hFD);
    for (int k = 0; k < 12; k++) begin pulseTick(0); chkAll("R7"); end
    setMode(1, 0, 0, 3, 0); chkAll("R8");

    // R8 / R9 PWM with deferred duty
    setMode(0, 0, 0, 0, 0);
    wrReg(2'd0, 8'h00);
    setMode(0, 0, 0, 2, 0);
    wrReg(2'd0, 8'h40); chkAll("R9");
    for (int k = 0; k < 300; k++) begin pulseTick(0); chkAll("R8_R9"); end
    wrReg(2'd0, 8'h20); chkAll("R9");
    for (int k = 0; k < 300; k++) begin pulseTick(0); chkAll("R8_R9"); end

    // R9 immediate duty under reload
    setMode(1, 0, 0, 2, 0);
    wrReg(2'd0, 8'h10); chkAll("R9");
    chk("R9", countOut, 0, "restart");
    for (int k = 0; k < 40; k++) begin pulseTick(0); chkAll("R8_R9"); end

    // R10 standby
    setMode(1, 1, 0, 1, 0);
    wrReg(2'd0, 8'hFE);
    pulseTick(1); chkAll("R10");
    setMode(1, 1, 0, 1, 1);
    for (int k = 0; k < 5; k++) begin pulseTick(1); chkAll("R10"); end
    setMode(1, 1, 0, 1, 0);
    for (int k = 0; k < 5; k++) begin pulseTick(1); chkAll("R10"); end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule